// File: doc/BRIEF.md
# Burst and Soft-Start Peak-Current Limit Governor

This block sets the peak-current limit code and the switching enable for a current-mode flyback controller. Two comparator flags describe the feedback level. One says feedback sits below the upper burst threshold, and the other says it sits below the lower one. A one-cycle restart pulse arrives from the protection supervisor at power-up and at every auto-restart attempt. The limit code drives the pulse-terminating comparator. The enable gates the oscillator's turn-on pulses.

After reset or restart, a soft-start ramp raises the limit code from its floor (0) to its full value (all ones) in fifteen equal steps. A prescaled clock counter times each step. When light load pulls feedback under the upper threshold, the block enters burst operation. Switching continues, but the limit is forced to a fixed parameter code that is higher than the feedback would ask for, so feedback keeps falling. Under the lower threshold, switching stops. Switching resumes in normal operation only when feedback climbs back above the upper threshold. Between the two thresholds the block holds whatever it was doing.

Top module: `burst_softstart_ilim`

## Requirements
- R1: While reset is held, and right after it, `ilim_code_o` is 0 and `sw_en_o` is 1. The block is in normal run with the ramp at its floor.
- R2: The ramp code starts at 0 after reset or restart. It rises by exactly one every TICK_DIV clock cycles, and the first step lands on the TICK_DIV-th rising edge.
- R3: The ramp saturates at the all-ones code (15 for CODE_W = 4) and stays there until the next reset or restart.
- R4: A restart pulse sampled high returns the ramp to 0 and the burst state to normal run at that edge, after which the ramp runs again from the floor.
- R5: Each flag passes through a two-flop synchronizer. A flag change made between edges first affects the outputs after the third rising edge.
- R6: In normal run, a set upper flag (feedback below the upper threshold) moves the block to burst-switching. There `sw_en_o` = 1 and `ilim_code_o` = BURST_CODE.
- R7: In burst-switching, a set lower flag stops switching: `sw_en_o` = 0 and `ilim_code_o` stays BURST_CODE.
- R8: With switching stopped, the block returns to normal run once both flags are clear (feedback above the upper threshold). Then `sw_en_o` = 1 and `ilim_code_o` shows the ramp code.
- R9: Feedback between the thresholds (upper flag 1, lower flag 0) changes nothing. Stopped stays stopped, and burst-switching stays burst-switching.
- R10: In burst-switching, both flags clear returns the block to normal run with the ramp code.
- R11: Switching never stops directly from normal run. An inconsistent pair (lower flag 1, upper flag 0) counts as below both thresholds. From normal run it takes one cycle in burst-switching, then stops.
- R12: The burst code overrides the ramp at any ramp position, including during soft-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fb_below_hi_i | input | 1 | Feedback below upper burst threshold (asynchronous) |
| fb_below_lo_i | input | 1 | Feedback below lower burst threshold (asynchronous) |
| restart_i | input | 1 | One-cycle restart pulse from the supervisor, synchronous |
| ilim_code_o | output | CODE_W | Peak-current limit code to the pulse comparator |
| sw_en_o | output | 1 | Switching enable |

## Verification
The main target is hysteresis. Feedback parked between the thresholds is held for many cycles, both with switching stopped and in burst-switching. A design that compares against a single threshold would toggle `sw_en_o` or fall back to the ramp code there. Ramp timing is checked one cycle before and one cycle after a step, so an off-by-one prescaler shows up as a wrong code. Checks also confirm saturation and the re-run after a restart pulse, and a missing restart clear would leave the limit at full value. Synchronizer latency is probed on the second and third edges after a flag change. The inconsistent-flag case confirms that switching never drops straight from normal run.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_BURST_ON  = 2'd1,
    ST_BURST_OFF = 2'd2
  } burst_st_e;
endpackage

// File: rtl/bsl_sync.sv
module bsl_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bsl_ramp.sv
module bsl_ramp #(
  parameter int CODE_W   = 4,
  parameter int TICK_DIV = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  output logic [CODE_W-1:0] ramp_o
);
  localparam int                DIV_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [CODE_W-1:0] RAMP_MAX = '1;

  logic [DIV_W-1:0]  cnt_q;
  logic [CODE_W-1:0] ramp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ramp_q <= '0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      ramp_q <= '0;
    end else if (ramp_q != RAMP_MAX) begin
      if (cnt_q == DIV_LAST) begin
        cnt_q  <= '0;
        ramp_q <= ramp_q + 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign ramp_o = ramp_q;
endmodule

// File: rtl/bsl_burst_fsm.sv
module bsl_burst_fsm
  import bsl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      restart_i,
  input  logic      below_hi_i,
  input  logic      below_lo_i,
  output burst_st_e st_o
);
  burst_st_e st_q, st_d;
  logic      hi_eff;

  // a lower-threshold crossing implies the upper one
  assign hi_eff = below_hi_i | below_lo_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:       if (hi_eff) st_d = ST_BURST_ON;
      ST_BURST_ON:  if (below_lo_i) st_d = ST_BURST_OFF;
                    else if (!hi_eff) st_d = ST_RUN;
      ST_BURST_OFF: if (!hi_eff) st_d = ST_RUN;
      default:      st_d = ST_RUN;
    endcase
    if (restart_i) st_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;

  assign st_o = st_q;
endmodule

// File: rtl/burst_softstart_ilim.sv
module burst_softstart_ilim
  import bsl_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter int TICK_DIV    = 250000,
  parameter int BURST_CODE  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fb_below_hi_i,
  input  logic              fb_below_lo_i,
  input  logic              restart_i,
  output logic [CODE_W-1:0] ilim_code_o,
  output logic              sw_en_o
);
  localparam logic [CODE_W-1:0] BURST_LIM = CODE_W'(BURST_CODE);

  logic [1:0]        flags_s;
  logic [CODE_W-1:0] ramp_q;
  burst_st_e         st;

  bsl_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({fb_below_lo_i, fb_below_hi_i}),
    .q_o    (flags_s)
  );

  bsl_ramp #(.CODE_W(CODE_W), .TICK_DIV(TICK_DIV)) u_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .ramp_o    (ramp_q)
  );

  bsl_burst_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart_i),
    .below_hi_i (flags_s[0]),
    .below_lo_i (flags_s[1]),
    .st_o       (st)
  );

  assign sw_en_o     = (st != ST_BURST_OFF);
  assign ilim_code_o = (st == ST_RUN) ? ramp_q : BURST_LIM;
endmodule

// File: rtl/bsl_checker.sv
module bsl_checker #(
  parameter int CODE_W     = 4,
  parameter int BURST_CODE = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              restart_i,
  input logic              sw_en_i,
  input logic [CODE_W-1:0] ilim_code_i,
  input logic [CODE_W-1:0] ramp_i
);
  localparam logic [CODE_W-1:0] RMAX = '1;
  localparam logic [CODE_W-1:0] BLIM = CODE_W'(BURST_CODE);

  p_restart_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> ramp_i == '0);

  p_ramp_single_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && ramp_i != RMAX) |=>
      (ramp_i == $past(ramp_i) || ramp_i == $past(ramp_i) + 1'b1));

  p_ramp_saturate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && ramp_i == RMAX) |=> ramp_i == RMAX);

  p_off_shows_burst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en_i |-> ilim_code_i == BLIM);

  p_stop_from_burst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_en_i) |-> $past(ilim_code_i) == BLIM);
endmodule

bind burst_softstart_ilim bsl_checker #(
  .CODE_W     (CODE_W),
  .BURST_CODE (BURST_CODE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .restart_i   (restart_i),
  .sw_en_i     (sw_en_o),
  .ilim_code_i (ilim_code_o),
  .ramp_i      (ramp_q)
);

// File: tb/burst_softstart_ilim_tb.sv
`timescale 1ns/1ps
module burst_softstart_ilim_tb;
  localparam int DIV   = 8;
  localparam int BCODE = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bh = 1'b0, bl = 1'b0, rs = 1'b0;
  logic [3:0] code;
  logic       sw;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0, rnd_on = 1'b0;

  always #2 clk = ~clk;

  burst_softstart_ilim #(.CODE_W(4), .TICK_DIV(DIV), .BURST_CODE(BCODE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fb_below_hi_i(bh), .fb_below_lo_i(bl),
    .restart_i(rs), .ilim_code_o(code), .sw_en_o(sw)
  );

  // reference model: 0 run, 1 burst switching, 2 stopped
  int m_st, m_ramp, m_cnt;
  bit m_h1, m_h2, m_l1, m_l2;

  function automatic int nxt_st(int st, bit h, bit l);
    bit he = h | l;
    case (st)
      0: return he ? 1 : 0;
      1: return l ? 2 : (!he ? 0 : 1);
      default: return he ? 2 : 0;
    endcase
  endfunction

  function automatic int exp_code(int st, int ramp);
    return (st == 0) ? ramp : BCODE;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ramp = 0; m_cnt = 0;
      m_h1 = 0; m_h2 = 0; m_l1 = 0; m_l2 = 0;
    end else begin
      m_st = rs ? 0 : nxt_st(m_st, m_h2, m_l2);
      if (rs) begin m_ramp = 0; m_cnt = 0; end
      else if (m_ramp < 15) begin
        if (m_cnt == DIV - 1) begin m_cnt = 0; m_ramp++; end
        else m_cnt++;
      end
      m_h2 = m_h1; m_l2 = m_l1; m_h1 = bh; m_l1 = bl;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_fb(input bit h, input bit l);
    bh = h; bl = l;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  always @(negedge clk) if (rnd_on) begin
    chk("R2/R6/R8", code, exp_code(m_st, m_ramp));
    chk("R7/R9", sw, (m_st != 2));
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    tick(3);
    chk("R1 code", code, 0);
    chk("R1 sw", sw, 1);
    rst_n = 1'b1;
    tick(23);
    chk("R2 before step", code, 2);
    tick(1);
    chk("R2 at step", code, 3);
    tick(100);
    chk("R3 full", code, 15);
    tick(16);
    chk("R3 saturated", code, 15);

    set_fb(1, 0);
    tick(2);
    chk("R5 not yet", code, 15);
    tick(1);
    chk("R6 code", code, BCODE);
    chk("R6 sw", sw, 1);

    set_fb(1, 1);
    tick(3);
    chk("R7 sw", sw, 0);
    chk("R7 code", code, BCODE);

    set_fb(1, 0);
    for (int i = 0; i < 20; i++) begin
      tick(1);
      chk("R9 stopped holds", sw, 0);
    end

    set_fb(0, 0);
    tick(3);
    chk("R8 sw", sw, 1);
    chk("R8 code", code, 15);

    set_fb(1, 0);
    tick(3);
    for (int i = 0; i < 20; i++) begin
      tick(1);
      chk("R9 burst holds sw", sw, 1);
      chk("R9 burst holds code", code, BCODE);
    end

    set_fb(0, 0);
    tick(3);
    chk("R10 code", code, 15);

    set_fb(0, 1);
    tick(3);
    chk("R11 via burst sw", sw, 1);
    chk("R11 via burst code", code, BCODE);
    tick(1);
    chk("R11 stopped", sw, 0);
    set_fb(0, 0);
    tick(3);
    chk("R8 back", sw, 1);

    rs = 1'b1;
    @(posedge clk); @(negedge clk);
    rs = 1'b0;
    chk("R4 floor", code, 0);
    tick(7);
    chk("R4 rerun before", code, 0);
    tick(1);
    chk("R4 rerun step", code, 1);
    set_fb(1, 0);
    tick(3);
    chk("R12 burst in soft-start", code, BCODE);
    set_fb(0, 0);
    tick(3);
    chk("R12 ramp resumes", code, 1);

    rnd_on = 1'b1;
    for (int seg = 0; seg < 1500; seg++) begin
      int lvl = $urandom_range(0, 9);
      if (lvl < 3) set_fb(0, 0);
      else if (lvl < 6) set_fb(1, 0);
      else if (lvl < 9) set_fb(1, 1);
      else set_fb(0, 1);
      if ($urandom_range(0, 39) == 0) begin
        rs = 1'b1;
        @(negedge clk);
        rs = 1'b0;
      end
      repeat ($urandom_range(1, 10)) @(negedge clk);
    end
    rnd_on = 1'b0;
    finish_run();
  end
endmodule